// File: doc/BRIEF.md
# ADC Conversion Result and Status Register

This block holds the outcome of an analog-to-digital conversion for a processor to read. Each time the conversion engine signals completion, the block captures the 12-bit sample and the 3-bit number of the channel that produced it. It raises a completion flag that a read of the register clears. In burst mode, a fresh sample that replaces one software never read also raises an overrun flag. Everything is presented as one 32-bit read word.

The block also sees writes to the converter's control register. Each such write sends a one-cycle start request to the engine. A small sequencer tracks whether a conversion is in flight. It has two states. ST_IDLE means no conversion is running. ST_CONV means one is running. There are four named transitions:

- T_LAUNCH (ST_IDLE to ST_CONV): a control write.
- T_FINISH (ST_CONV to ST_IDLE): a completion outside burst mode with no control write in the same cycle.
- T_RESTART (ST_CONV to ST_CONV): a control write while busy. This sets the completion flag and starts a new conversion.
- T_CHAIN (ST_CONV to ST_CONV): a completion in burst mode, after which the engine keeps converting.

A control write from ST_IDLE clears the completion flag.

Top module: `adc_result_reg`

## Requirements
- R1: After reset, `rd_data` is all zeros and `start_req` is 0.
- R2: One cycle after `conv_done`, `rd_data[15:4]` holds the captured sample, `rd_data[26:24]` holds the captured channel number in binary, and `rd_data[31]` (completion flag) is 1.
- R3: Bits 3:0, 23:16 and 30:28 of `rd_data` are always 0.
- R4: In the cycle where `res_rd` is asserted, `rd_data` shows the values from before the read. In the next cycle, bit 31 and bit 27 (overrun flag) are both 0, unless a completion or a control write lands in the same cycle.
- R5: If `res_rd` and `conv_done` land in the same cycle, the new sample is captured, bit 31 stays 1 and bit 27 is not set.
- R6: With `burst_mode` high, a `conv_done` while bit 31 is 1 and no read is pending sets bit 27.
- R7: With `burst_mode` low, a `conv_done` that replaces an unread sample updates the sample but leaves bit 27 at 0.
- R8: A control write in ST_IDLE clears bit 31 in the next cycle and enters ST_CONV.
- R9: A control write in ST_CONV sets bit 31 in the next cycle, even though no sample arrived.
- R10: `start_req` is 1 in exactly the cycle after each cycle where `ctrl_wr` is asserted, and 0 otherwise.
- R11: A non-burst completion returns the sequencer to ST_IDLE. A later control write therefore clears bit 31.
- R12: A burst completion keeps the sequencer in ST_CONV. A later control write therefore sets bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | Conversion-complete strobe from the engine |
| conv_result | input | 12 | Sample that goes with `conv_done` |
| conv_chan | input | 3 | Channel number that goes with `conv_done` |
| burst_mode | input | 1 | High while the engine converts back to back |
| res_rd | input | 1 | Bus read of this register |
| ctrl_wr | input | 1 | Bus write to the converter control register |
| rd_data | output | 32 | Packed result and status word |
| start_req | output | 1 | One-cycle request for the engine to start a conversion |

## Verification
The bench checks the following corner cases and the failure each one would expose:

- A read and a completion in the same cycle. A design that lets the clear win would lose a sample's completion flag.
- Back-to-back unread completions in both modes. A design that ignores the mode would raise a false overrun, or miss a real one.
- Control writes issued from each sequencer state. A sequencer that never leaves ST_CONV, or never enters it, would clear the flag where it should set it, or set it where it should clear it.
- Reserved bits and the timing of the start pulse, checked on every cycle.

// File: rtl/adcres_pkg.sv
package adcres_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_t;

endpackage

// File: rtl/adcres_seq.sv
module adcres_seq
    import adcres_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic conv_done,
    input  logic burst_mode,
    output logic busy,
    output logic restart,
    output logic start_req
);

    seq_state_t state_q;
    seq_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr) begin
                    state_d = ST_CONV;                  // T_LAUNCH
                end
            end
            ST_CONV: begin
                if (ctrl_wr) begin
                    state_d = ST_CONV;                  // T_RESTART
                end else if (conv_done && burst_mode) begin
                    state_d = ST_CONV;                  // T_CHAIN
                end else if (conv_done) begin
                    state_d = ST_IDLE;                  // T_FINISH
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state_q == ST_CONV);
        restart = ctrl_wr && (state_q == ST_CONV);
    end

    // one-cycle start request, one per control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_req <= 1'b0;
        end else begin
            start_req <= ctrl_wr;
        end
    end

endmodule

// File: rtl/adcres_hold.sv
module adcres_hold #(
    parameter int RES_W  = 12,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic [CHAN_W-1:0] conv_chan,
    input  logic              burst_mode,
    input  logic              res_rd,
    input  logic              ctrl_wr,
    input  logic              restart,
    output logic [RES_W-1:0]  res_q,
    output logic [CHAN_W-1:0] chan_q,
    output logic              done_q,
    output logic              ovr_q
);

    logic done_d;
    logic ovr_d;
    logic lost_unread;

    // a burst completion replacing a sample nobody read
    assign lost_unread = conv_done && burst_mode && done_q && !res_rd;

    always_comb begin
        done_d = done_q;
        if (conv_done) begin
            done_d = 1'b1;
        end else if (ctrl_wr) begin
            done_d = restart;
        end else if (res_rd) begin
            done_d = 1'b0;
        end
    end

    always_comb begin
        ovr_d = ovr_q;
        if (lost_unread) begin
            ovr_d = 1'b1;
        end else if (res_rd) begin
            ovr_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            chan_q <= '0;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (conv_done) begin
                res_q  <= conv_result;
                chan_q <= conv_chan;
            end
            done_q <= done_d;
            ovr_q  <= ovr_d;
        end
    end

endmodule

// File: rtl/adcres_pack.sv
module adcres_pack #(
    parameter int DATA_W   = 32,
    parameter int RES_W    = 12,
    parameter int CHAN_W   = 3,
    parameter int RES_LSB  = 4,
    parameter int CHAN_LSB = 24,
    parameter int OVR_BIT  = 27,
    parameter int DONE_BIT = 31
) (
    input  logic [RES_W-1:0]  res_q,
    input  logic [CHAN_W-1:0] chan_q,
    input  logic              done_q,
    input  logic              ovr_q,
    output logic [DATA_W-1:0] word
);

    always_comb begin
        word                         = '0;
        word[RES_LSB +: RES_W]       = res_q;
        word[CHAN_LSB +: CHAN_W]     = chan_q;
        word[OVR_BIT]                = ovr_q;
        word[DONE_BIT]               = done_q;
    end

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
    parameter int DATA_W   = 32,
    parameter int RES_W    = 12,
    parameter int CHAN_W   = 3,
    parameter int RES_LSB  = 4,
    parameter int CHAN_LSB = 24,
    parameter int OVR_BIT  = 27,
    parameter int DONE_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic [CHAN_W-1:0] conv_chan,
    input  logic              burst_mode,
    input  logic              res_rd,
    input  logic              ctrl_wr,
    output logic [DATA_W-1:0] rd_data,
    output logic              start_req
);

    localparam int RES_MSB  = RES_LSB + RES_W - 1;
    localparam int CHAN_MSB = CHAN_LSB + CHAN_W - 1;

    generate
        if (RES_MSB >= CHAN_LSB || CHAN_MSB >= OVR_BIT || OVR_BIT >= DONE_BIT
            || DONE_BIT >= DATA_W) begin : g_bad_layout
            initial $error("adc_result_reg: field layout overlaps or overflows");
        end
    endgenerate

    logic              busy;
    logic              restart;
    logic [RES_W-1:0]  res_q;
    logic [CHAN_W-1:0] chan_q;
    logic              done_q;
    logic              ovr_q;

    adcres_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .conv_done  (conv_done),
        .burst_mode (burst_mode),
        .busy       (busy),
        .restart    (restart),
        .start_req  (start_req)
    );

    adcres_hold #(
        .RES_W  (RES_W),
        .CHAN_W (CHAN_W)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .conv_chan   (conv_chan),
        .burst_mode  (burst_mode),
        .res_rd      (res_rd),
        .ctrl_wr     (ctrl_wr),
        .restart     (restart),
        .res_q       (res_q),
        .chan_q      (chan_q),
        .done_q      (done_q),
        .ovr_q       (ovr_q)
    );

    adcres_pack #(
        .DATA_W   (DATA_W),
        .RES_W    (RES_W),
        .CHAN_W   (CHAN_W),
        .RES_LSB  (RES_LSB),
        .CHAN_LSB (CHAN_LSB),
        .OVR_BIT  (OVR_BIT),
        .DONE_BIT (DONE_BIT)
    ) u_pack (
        .res_q  (res_q),
        .chan_q (chan_q),
        .done_q (done_q),
        .ovr_q  (ovr_q),
        .word   (rd_data)
    );

    logic unused_busy;
    assign unused_busy = busy;

endmodule

// File: rtl/adcres_chk.sv
module adcres_chk #(
    parameter int DATA_W   = 32,
    parameter int RES_W    = 12,
    parameter int CHAN_W   = 3,
    parameter int RES_LSB  = 4,
    parameter int CHAN_LSB = 24,
    parameter int OVR_BIT  = 27,
    parameter int DONE_BIT = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [RES_W-1:0]  conv_result,
    input logic [CHAN_W-1:0] conv_chan,
    input logic              burst_mode,
    input logic              res_rd,
    input logic              ctrl_wr,
    input logic [DATA_W-1:0] rd_data,
    input logic              start_req
);

    function automatic logic [DATA_W-1:0] used_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        m[RES_LSB +: RES_W]   = '1;
        m[CHAN_LSB +: CHAN_W] = '1;
        m[OVR_BIT]            = 1'b1;
        m[DONE_BIT]           = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] USED = used_mask();

    // R3
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~USED) == '0);

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> rd_data[DONE_BIT]
                   && rd_data[RES_LSB +: RES_W] == $past(conv_result)
                   && rd_data[CHAN_LSB +: CHAN_W] == $past(conv_chan));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd && !conv_done && !ctrl_wr) |=> !rd_data[DONE_BIT] && !rd_data[OVR_BIT]);

    // R10
    start_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> start_req);

    // R10
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> !start_req);

    // R7
    ovr_burst_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_done && burst_mode) |=> !$rose(rd_data[OVR_BIT]));

    // R5
    read_meets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && res_rd) |=> rd_data[DONE_BIT] && !$rose(rd_data[OVR_BIT]));

endmodule

bind adc_result_reg adcres_chk #(
    .DATA_W   (DATA_W),
    .RES_W    (RES_W),
    .CHAN_W   (CHAN_W),
    .RES_LSB  (RES_LSB),
    .CHAN_LSB (CHAN_LSB),
    .OVR_BIT  (OVR_BIT),
    .DONE_BIT (DONE_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .conv_chan   (conv_chan),
    .burst_mode  (burst_mode),
    .res_rd      (res_rd),
    .ctrl_wr     (ctrl_wr),
    .rd_data     (rd_data),
    .start_req   (start_req)
);

// File: tb/tb_adc_result_reg.sv
module tb_adc_result_reg;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic [2:0]  conv_chan = '0;
    logic        burst_mode = 1'b0;
    logic        res_rd = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] rd_data;
    logic        start_req;

    adc_result_reg dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .conv_chan   (conv_chan),
        .burst_mode  (burst_mode),
        .res_rd      (res_rd),
        .ctrl_wr     (ctrl_wr),
        .rd_data     (rd_data),
        .start_req   (start_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int          due;
        logic [31:0] word;
        logic        start;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;

    // reference model state, built from the requirements
    logic [11:0] m_res = '0;
    logic [2:0]  m_ch = '0;
    logic        m_done = 1'b0;
    logic        m_ovr = 1'b0;
    logic        m_busy = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk_word(logic [11:0] r, logic [2:0] c, logic o, logic d);
        logic [31:0] w;
        w = '0;
        w[15:4]  = r;
        w[26:24] = c;
        w[27]    = o;
        w[31]    = d;
        return w;
    endfunction

    task automatic check_word(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s rd_data act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_start(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s start_req act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    // monitor: compare results that fall due in this cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            check_word(rd_data, e.word, e.tag);
            check_start(start_req, e.start, e.tag);
        end
    end

    // driver: apply one cycle of stimulus and push its expected outcome
    task automatic op(input logic cw, input logic rd, input logic cd,
                      input logic [11:0] r, input logic [2:0] c,
                      input logic bm, input string tag);
        exp_t        e;
        logic        n_done;
        logic        n_ovr;
        logic        n_busy;
        @(posedge clk);
        #1;
        ctrl_wr     = cw;
        res_rd      = rd;
        conv_done   = cd;
        conv_result = r;
        conv_chan   = c;
        burst_mode  = bm;
        if (cd && bm && m_done && !rd) n_ovr = 1'b1;
        else if (rd)                   n_ovr = 1'b0;
        else                           n_ovr = m_ovr;
        if (cd)      n_done = 1'b1;
        else if (cw) n_done = m_busy;
        else if (rd) n_done = 1'b0;
        else         n_done = m_done;
        if (cw)                        n_busy = 1'b1;
        else if (m_busy && cd && !bm)  n_busy = 1'b0;
        else                           n_busy = m_busy;
        if (cd) begin
            m_res = r;
            m_ch  = c;
        end
        m_done = n_done;
        m_ovr  = n_ovr;
        m_busy = n_busy;
        e.due   = cyc + 1;
        e.word  = mk_word(m_res, m_ch, m_ovr, m_done);
        e.start = cw;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input logic bm, input string tag);
        op(1'b0, 1'b0, 1'b0, 12'h000, 3'd0, bm, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_word(rd_data, 32'h0, "R1 reset word");
        check_start(start_req, 1'b0, "R1 reset start");

        op(1'b1, 1'b0, 1'b0, 12'h000, 3'd0, 1'b0, "R8 launch from idle");
        idle(1'b0, "R10 start pulse ends");
        op(1'b0, 1'b0, 1'b1, 12'hABC, 3'd3, 1'b0, "R2 capture ch3 R3");
        idle(1'b0, "R11 finish holds");
        op(1'b0, 1'b1, 1'b0, 12'h000, 3'd0, 1'b0, "R4 read shows pre-read");
        idle(1'b0, "R4 read cleared");

        op(1'b0, 1'b0, 1'b1, 12'h123, 3'd5, 1'b0, "R2 capture ch5");
        op(1'b0, 1'b0, 1'b1, 12'h456, 3'd6, 1'b0, "R7 overwrite no overrun");
        idle(1'b0, "R7 hold");
        op(1'b0, 1'b1, 1'b0, 12'h000, 3'd0, 1'b0, "R4 read");

        op(1'b1, 1'b0, 1'b0, 12'h000, 3'd0, 1'b1, "R8 launch burst");
        op(1'b0, 1'b0, 1'b1, 12'h111, 3'd1, 1'b1, "R2 burst sample");
        op(1'b0, 1'b0, 1'b1, 12'h222, 3'd2, 1'b1, "R6 overrun set");
        idle(1'b1, "R6 overrun held");
        op(1'b0, 1'b1, 1'b0, 12'h000, 3'd0, 1'b1, "R4 read clears both");
        op(1'b0, 1'b0, 1'b1, 12'h333, 3'd4, 1'b1, "R2 next burst sample");
        op(1'b0, 1'b1, 1'b1, 12'h7FF, 3'd7, 1'b1, "R5 read meets completion");
        idle(1'b1, "R5 done kept");
        op(1'b0, 1'b1, 1'b0, 12'h000, 3'd0, 1'b1, "R4 read");
        op(1'b1, 1'b0, 1'b0, 12'h000, 3'd0, 1'b1, "R9 restart sets done");
        idle(1'b1, "R12 chain kept busy");
        op(1'b0, 1'b1, 1'b0, 12'h000, 3'd0, 1'b1, "R4 read");
        op(1'b1, 1'b0, 1'b0, 12'h000, 3'd0, 1'b1, "R12 write after chain sets done");

        op(1'b0, 1'b0, 1'b1, 12'hFFF, 3'd0, 1'b0, "R2 non-burst completion");
        op(1'b1, 1'b0, 1'b0, 12'h000, 3'd0, 1'b0, "R11 write after finish clears");
        op(1'b1, 1'b0, 1'b0, 12'h000, 3'd0, 1'b0, "R9 back-to-back write restart");
        idle(1'b0, "R10 pulse per write");
        op(1'b1, 1'b0, 1'b1, 12'h5A5, 3'd2, 1'b0, "R2 write with completion");
        idle(1'b0, "R10 end");
        idle(1'b0, "R3 final");

        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule